// File: doc/BRIEF.md
# Dual 40-bit Saturating Accumulator Unit

This block holds two signed 40-bit accumulators and updates one of them per clock. The update is a signed 16×16 multiply-accumulate, an add of the other accumulator, a load of a 32-bit value built from the two operands, or an arithmetic shift by a signed amount. Each update completes in one clock.

Every result is first formed exactly in a wide intermediate, so that two overflow levels can be judged on it. A result that leaves the signed 32-bit range has spilled into the guard bits 39..32. A result that leaves the signed 40-bit range is a catastrophic overflow. Each accumulator has its own saturation enable, and that enable decides how a catastrophic overflow is handled. With saturation on, the result clamps to the nearest 40-bit extreme. With saturation off, the result wraps and a one-cycle arithmetic trap request is raised.

Status flags are kept per accumulator and are sticky until a clear input is pulsed. Decoding instructions, fetching operands and vectoring the trap all belong to the surrounding logic.

Top module: `dacc_unit`

## Requirements
- R1: During and after reset, both accumulators read zero and every status flag and `trap_req` are low.
- R2: Opcode 1 (MAC) adds the signed product `op_a*op_b` into the accumulator chosen by `acc_sel` (0 = first, 1 = second). The new value shows on the output after the next rising edge, and the unselected accumulator keeps its value.
- R3: Opcode 3 (LOAD) writes the sign extension of the 32-bit value `{op_a, op_b}` into the selected accumulator. `op_a` forms the upper half.
- R4: Opcode 2 (ADD) adds the unselected accumulator into the selected one.
- R5: Opcode 4 (SHIFT) reads `shamt` as a 6-bit two's-complement number. Values 1 to 15 shift right arithmetically by that many places. Values -1 to -16 shift left by the magnitude. Value 0 leaves the accumulator unchanged.
- R6: A SHIFT whose `shamt` is 16..31 or -32..-17 changes neither the accumulator nor any flag, and raises no trap.
- R7: An update whose exact result lies outside the signed 32-bit range sets that accumulator's sticky `guard_ovf` bit. Bit 0 belongs to the first accumulator and bit 1 to the second.
- R8: When the accumulator's `sat_en` bit is 1 and the exact result lies outside the signed 40-bit range, the stored value is 0x7F_FFFF_FFFF for a positive result and 0x80_0000_0000 for a negative one. The sticky `sat_hit` bit is set and `trap_req` stays low.
- R9: When `sat_en` is 0 and the exact result lies outside the signed 40-bit range, the stored value is its low 40 bits. The sticky `cat_ovf` bit is set and `trap_req` is high for exactly the one cycle in which the wrapped value first shows.
- R10: A high `stat_clr` at a rising edge clears all sticky flags. A flag event in that same update still leaves its flag set.
- R11: Opcodes 0, 5, 6 and 7 change no accumulator and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 16 | First operand (signed) |
| op_b | input | 16 | Second operand (signed) |
| acc_sel | input | 1 | Accumulator chosen for update |
| opcode | input | 3 | Operation code |
| shamt | input | 6 | Signed shift amount |
| sat_en | input | 2 | Saturation enable per accumulator |
| stat_clr | input | 1 | Clear of all sticky flags |
| acc_a | output | 40 | First accumulator |
| acc_b | output | 40 | Second accumulator |
| guard_ovf | output | 2 | Sticky guard-bit overflow flags |
| sat_hit | output | 2 | Sticky saturation-occurred flags |
| cat_ovf | output | 2 | Sticky unsaturated catastrophic-overflow flags |
| trap_req | output | 1 | One-cycle arithmetic trap request |

## Verification
The bench builds the unit with its default parameters: 16-bit operands, 40-bit accumulators, up to 16 places of left shift and 15 of right shift, and saturation hardware present. With these values, a full-scale 32-bit load followed by a 16-place left shift crosses the 40-bit limit in one step. That brings both clamp extremes, the wrap path with its trap pulse, and the guard-only band between bit 31 and bit 39 within reach of short directed sequences. A seeded stream of mixed opcodes, saturation settings, clears and shift amounts then compares both accumulators and all flags with a scoreboard model, cycle by cycle.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
   localparam int OPC_W = 3;

   typedef enum logic [OPC_W-1:0] {
      OP_NOP   = 3'd0,
      OP_MAC   = 3'd1,
      OP_ADD   = 3'd2,
      OP_LOAD  = 3'd3,
      OP_SHIFT = 3'd4
   } dacc_op_e;

   typedef struct packed {
      logic guard;
      logic sat;
      logic cat;
   } dacc_flags_t;
endpackage

// File: rtl/dacc_mul.sv
module dacc_mul #(
   parameter int OP_W = 16
) (
   input  logic signed [OP_W-1:0]   mul_x,
   input  logic signed [OP_W-1:0]   mul_y,
   output logic signed [2*OP_W-1:0] mul_p
);
   assign mul_p = mul_x * mul_y;
endmodule

// File: rtl/dacc_shift.sv
module dacc_shift #(
   parameter int ACC_W   = 40,
   parameter int WIDE_W  = 57,
   parameter int SH_W    = 6,
   parameter int SHL_MAX = 16,
   parameter int SHR_MAX = 15
) (
   input  logic signed [ACC_W-1:0]  sh_in,
   input  logic signed [SH_W-1:0]   sh_amt,
   output logic signed [WIDE_W-1:0] sh_out,
   output logic                     sh_ok
);
   logic signed [WIDE_W-1:0] ext;
   int amt_i;

   assign ext = WIDE_W'(sh_in);

   always_comb begin
      amt_i  = int'(sh_amt);
      sh_out = ext;
      sh_ok  = 1'b0;
      if (amt_i == 0) begin
         sh_ok = 1'b1;
      end else if (amt_i > 0 && amt_i <= SHR_MAX) begin
         sh_out = ext >>> amt_i;
         sh_ok  = 1'b1;
      end else if (amt_i < 0 && -amt_i <= SHL_MAX) begin
         sh_out = ext <<< (-amt_i);
         sh_ok  = 1'b1;
      end
   end
endmodule

// File: rtl/dacc_sat.sv
module dacc_sat #(
   parameter int ACC_W   = 40,
   parameter int WIDE_W  = 57,
   parameter int GUARD_W = 32,
   parameter bit HAS_SAT = 1'b1
) (
   input  logic signed [WIDE_W-1:0] rs_wide,
   input  logic                     rs_sat_on,
   output logic signed [ACC_W-1:0]  rs_val,
   output logic                     rs_past_guard,
   output logic                     rs_past_acc
);
   localparam logic [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};

   logic [WIDE_W-ACC_W:0]   hi_acc;
   logic [WIDE_W-GUARD_W:0] hi_grd;
   logic [ACC_W-1:0]        wrapped;

   assign hi_acc        = rs_wide[WIDE_W-1:ACC_W-1];
   assign hi_grd        = rs_wide[WIDE_W-1:GUARD_W-1];
   assign rs_past_acc   = !((&hi_acc) || !(|hi_acc));
   assign rs_past_guard = !((&hi_grd) || !(|hi_grd));
   assign wrapped       = rs_wide[ACC_W-1:0];

   generate
      if (HAS_SAT) begin : g_clamp
         always_comb begin
            if (rs_past_acc && rs_sat_on)
               rs_val = rs_wide[WIDE_W-1] ? NEG_LIM : POS_LIM;
            else
               rs_val = wrapped;
         end
      end else begin : g_wrap_only
         assign rs_val = wrapped;
      end
   endgenerate
endmodule

// File: rtl/dacc_lane.sv
module dacc_lane
   import dacc_pkg::*;
#(
   parameter int OP_W    = 16,
   parameter int ACC_W   = 40,
   parameter int SH_W    = 6,
   parameter int SHL_MAX = 16,
   parameter int SHR_MAX = 15,
   parameter bit HAS_SAT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [OPC_W-1:0]        opcode,
   input  logic signed [OP_W-1:0]  op_a,
   input  logic signed [OP_W-1:0]  op_b,
   input  logic signed [ACC_W-1:0] other_acc,
   input  logic signed [SH_W-1:0]  shamt,
   input  logic                    sat_en,
   input  logic                    stat_clr,
   output logic signed [ACC_W-1:0] acc_q,
   output dacc_flags_t             flags_q,
   output logic                    trap_q
);
   localparam int PROD_W = 2 * OP_W;
   localparam int WIDE_W = ACC_W + SHL_MAX + 1;

   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] ld_word;
   logic signed [WIDE_W-1:0] ext_acc, ext_prod, ext_oth, ext_ld, sh_res, cand;
   logic signed [ACC_W-1:0]  nxt;
   logic                     sh_ok, has_res, upd, sat_eff, past_grd, past_acc;
   dacc_flags_t              ev;

   dacc_mul #(.OP_W(OP_W)) u_mul (
      .mul_x(op_a), .mul_y(op_b), .mul_p(prod)
   );

   dacc_shift #(.ACC_W(ACC_W), .WIDE_W(WIDE_W), .SH_W(SH_W),
                .SHL_MAX(SHL_MAX), .SHR_MAX(SHR_MAX)) u_shift (
      .sh_in(acc_q), .sh_amt(shamt), .sh_out(sh_res), .sh_ok(sh_ok)
   );

   assign ld_word  = {op_a, op_b};
   assign ext_acc  = WIDE_W'(acc_q);
   assign ext_prod = WIDE_W'(prod);
   assign ext_oth  = WIDE_W'(other_acc);
   assign ext_ld   = WIDE_W'(ld_word);
   assign sat_eff  = sat_en && HAS_SAT;

   always_comb begin
      cand    = ext_acc;
      has_res = 1'b1;
      case (opcode)
         OP_MAC:   cand = ext_acc + ext_prod;
         OP_ADD:   cand = ext_acc + ext_oth;
         OP_LOAD:  cand = ext_ld;
         OP_SHIFT: begin
            cand    = sh_res;
            has_res = sh_ok;
         end
         default:  has_res = 1'b0;
      endcase
   end

   assign upd = wr_en && has_res;

   dacc_sat #(.ACC_W(ACC_W), .WIDE_W(WIDE_W), .GUARD_W(PROD_W),
              .HAS_SAT(HAS_SAT)) u_sat (
      .rs_wide(cand), .rs_sat_on(sat_eff), .rs_val(nxt),
      .rs_past_guard(past_grd), .rs_past_acc(past_acc)
   );

   assign ev.guard = upd && past_grd;
   assign ev.sat   = upd && past_acc && sat_eff;
   assign ev.cat   = upd && past_acc && !sat_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         flags_q <= '0;
         trap_q  <= 1'b0;
      end else begin
         if (upd) acc_q <= nxt;
         flags_q <= (stat_clr ? dacc_flags_t'('0) : flags_q) | ev;
         trap_q  <= ev.cat;
      end
   end

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!wr_en) |-> $stable(acc_q));

   assert_shift_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && opcode == OP_SHIFT && !sh_ok) |-> $stable(acc_q));

   assert_trap_unsat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_q |-> ($past(!sat_eff) && flags_q.cat));

   assert_sat_no_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(upd && sat_eff) |-> !trap_q);

   assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(flags_q) & ~flags_q)) |-> $past(stat_clr));
endmodule

// File: rtl/dacc_unit.sv
module dacc_unit
   import dacc_pkg::*;
#(
   parameter int OP_W    = 16,
   parameter int ACC_W   = 40,
   parameter int SH_W    = 6,
   parameter int SHL_MAX = 16,
   parameter int SHR_MAX = 15,
   parameter bit HAS_SAT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [OP_W-1:0]    op_a,
   input  logic [OP_W-1:0]    op_b,
   input  logic               acc_sel,
   input  logic [OPC_W-1:0]   opcode,
   input  logic [SH_W-1:0]    shamt,
   input  logic [1:0]         sat_en,
   input  logic               stat_clr,
   output logic [ACC_W-1:0]   acc_a,
   output logic [ACC_W-1:0]   acc_b,
   output logic [1:0]         guard_ovf,
   output logic [1:0]         sat_hit,
   output logic [1:0]         cat_ovf,
   output logic               trap_req
);
   localparam int N_ACC  = 2;
   localparam int SH_LIM = 1 << (SH_W - 1);

   generate
      if (ACC_W < 2 * OP_W + 1) begin : g_chk_acc
         $error("dacc_unit: ACC_W must exceed the product width");
      end
      if (SHL_MAX > SH_LIM || SHR_MAX >= SH_LIM) begin : g_chk_sh
         $error("dacc_unit: SH_W too narrow for the shift limits");
      end
      if (SHL_MAX < 1 || SHR_MAX < 1) begin : g_chk_pos
         $error("dacc_unit: shift limits must be positive");
      end
   endgenerate

   logic signed [ACC_W-1:0] acc_vec [N_ACC];
   dacc_flags_t             flg_vec [N_ACC];
   logic [N_ACC-1:0]        trap_vec;

   generate
      for (genvar i = 0; i < N_ACC; i++) begin : g_lane
         dacc_lane #(.OP_W(OP_W), .ACC_W(ACC_W), .SH_W(SH_W),
                     .SHL_MAX(SHL_MAX), .SHR_MAX(SHR_MAX),
                     .HAS_SAT(HAS_SAT)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (acc_sel == 1'(i)),
            .opcode    (opcode),
            .op_a      (op_a),
            .op_b      (op_b),
            .other_acc (acc_vec[N_ACC-1-i]),
            .shamt     (shamt),
            .sat_en    (sat_en[i]),
            .stat_clr  (stat_clr),
            .acc_q     (acc_vec[i]),
            .flags_q   (flg_vec[i]),
            .trap_q    (trap_vec[i])
         );
         assign guard_ovf[i] = flg_vec[i].guard;
         assign sat_hit[i]   = flg_vec[i].sat;
         assign cat_ovf[i]   = flg_vec[i].cat;
      end
   endgenerate

   assign acc_a    = acc_vec[0];
   assign acc_b    = acc_vec[1];
   assign trap_req = |trap_vec;

   assert_one_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(trap_vec));

   assert_unsel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc_sel) |-> $stable(acc_a));
endmodule

// File: tb/tb_dacc_unit.sv
module tb_dacc_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] op_a = '0, op_b = '0;
   logic        acc_sel = 1'b0;
   logic [2:0]  opcode = '0;
   logic [5:0]  shamt = '0;
   logic [1:0]  sat_en = '0;
   logic        stat_clr = 1'b0;
   logic [39:0] acc_a, acc_b;
   logic [1:0]  guard_ovf, sat_hit, cat_ovf;
   logic        trap_req;

   dacc_unit dut (.*);

   always #10 clk = ~clk;

   typedef struct {
      longint ea, eb;
      logic [1:0] g, s, c;
      logic t;
      string tag;
   } exp_t;

   exp_t   q [$];
   int     checks = 0, failures = 0;
   bit     done = 1'b0;
   longint m_acc [2] = '{0, 0};
   logic [1:0] m_g = '0, m_s = '0, m_c = '0;

   localparam longint MAX40 = 64'sh7F_FFFF_FFFF;
   localparam longint MIN40 = -64'sh80_0000_0000;
   localparam longint MAX32 = 64'sh7FFF_FFFF;
   localparam longint MIN32 = -64'sh8000_0000;

   function automatic longint wrap40(longint v);
      logic signed [39:0] lo;
      lo = v[39:0];
      return longint'(lo);
   endfunction

   task automatic issue(input logic [2:0] op, input logic sel, input logic [15:0] a,
                        input logic [15:0] b, input logic [5:0] sh, input logic [1:0] sat,
                        input logic clr, input string tag);
      longint cur, ex;
      bit     act;
      int     s;
      exp_t   it;
      logic   gev, cev, sev;
      @(negedge clk);
      opcode = op; acc_sel = sel; op_a = a; op_b = b; shamt = sh;
      sat_en = sat; stat_clr = clr;
      cur = m_acc[sel]; ex = cur; act = 1'b1;
      case (op)
         3'd1: ex = cur + longint'($signed(a)) * longint'($signed(b));
         3'd2: ex = cur + m_acc[!sel];
         3'd3: ex = longint'($signed({a, b}));
         3'd4: begin
            s = int'($signed(sh));
            if (s == 0) ex = cur;
            else if (s > 0 && s <= 15) ex = cur >>> s;
            else if (s < 0 && s >= -16) ex = cur <<< (-s);
            else act = 1'b0;
         end
         default: act = 1'b0;
      endcase
      gev = act && (ex > MAX32 || ex < MIN32);
      cev = act && (ex > MAX40 || ex < MIN40);
      sev = cev && sat[sel];
      if (act) begin
         if (cev && sat[sel]) m_acc[sel] = (ex > 0) ? MAX40 : MIN40;
         else m_acc[sel] = wrap40(ex);
      end
      if (clr) begin m_g = '0; m_s = '0; m_c = '0; end
      m_g[sel] = m_g[sel] | gev;
      m_s[sel] = m_s[sel] | sev;
      m_c[sel] = m_c[sel] | (cev && !sev);
      it.ea = m_acc[0]; it.eb = m_acc[1];
      it.g = m_g; it.s = m_s; it.c = m_c; it.t = cev && !sev; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic nop(input int n);
      for (int i = 0; i < n; i++) issue(3'd0, 1'b0, 16'h0, 16'h0, 6'd0, 2'b00, 1'b0, "R11 idle");
   endtask

   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         longint aa, ab;
         e = q.pop_front();
         aa = longint'($signed(acc_a));
         ab = longint'($signed(acc_b));
         checks++;
         if (aa != e.ea || ab != e.eb || guard_ovf != e.g || sat_hit != e.s ||
             cat_ovf != e.c || trap_req !== e.t) begin
            failures++;
            $display("FAIL %s: actual a=%h b=%h g=%b s=%b c=%b t=%b expected a=%h b=%h g=%b s=%b c=%b t=%b",
                     e.tag, acc_a, acc_b, guard_ovf, sat_hit, cat_ovf, trap_req,
                     e.ea[39:0], e.eb[39:0], e.g, e.s, e.c, e.t);
         end
      end
   end

   initial begin
      #(20 * 5000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      bit [31:0] seed = 32'h1F2E3D4C;
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (acc_a != 0 || acc_b != 0 || guard_ovf != 0 || sat_hit != 0 || cat_ovf != 0 || trap_req !== 1'b0) begin
         failures++;
         $display("FAIL R1 reset: actual a=%h b=%h expected zero state", acc_a, acc_b);
      end
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      checks++;
      if (acc_a != 0 || acc_b != 0 || trap_req !== 1'b0) begin
         failures++;
         $display("FAIL R1 post-reset: actual a=%h b=%h expected 0 0", acc_a, acc_b);
      end
      // R3 loads, positive and negative
      issue(3'd3, 1'b0, 16'h1234, 16'h5678, 6'd0, 2'b00, 1'b0, "R3 load A");
      issue(3'd3, 1'b1, 16'h8000, 16'h0001, 6'd0, 2'b00, 1'b0, "R3 load B neg");
      // R2 MAC patterns
      issue(3'd1, 1'b0, 16'h7FFF, 16'h7FFF, 6'd0, 2'b00, 1'b0, "R2 mac pos");
      issue(3'd1, 1'b0, 16'h8000, 16'h0003, 6'd0, 2'b00, 1'b0, "R2 mac neg");
      issue(3'd1, 1'b1, 16'hFFFF, 16'hFFFF, 6'd0, 2'b00, 1'b0, "R2 mac B");
      // R4 add
      issue(3'd2, 1'b1, 16'h0, 16'h0, 6'd0, 2'b00, 1'b0, "R4 add B+=A");
      issue(3'd2, 1'b0, 16'h0, 16'h0, 6'd0, 2'b00, 1'b0, "R4 add A+=B");
      // R5 shifts
      issue(3'd3, 1'b0, 16'hF123, 16'h4567, 6'd0, 2'b00, 1'b0, "R3 load A neg");
      issue(3'd4, 1'b0, 16'h0, 16'h0, 6'd4, 2'b00, 1'b0, "R5 shr 4");
      issue(3'd4, 1'b0, 16'h0, 16'h0, 6'd15, 2'b00, 1'b0, "R5 shr 15");
      issue(3'd4, 1'b0, 16'h0, 16'h0, 6'd0, 2'b00, 1'b0, "R5 shift 0");
      issue(3'd3, 1'b0, 16'h0000, 16'h00AB, 6'd0, 2'b00, 1'b0, "R3 load small");
      issue(3'd4, 1'b0, 16'h0, 16'h0, 6'h38, 2'b00, 1'b0, "R5 shl 8");
      issue(3'd4, 1'b0, 16'h0, 16'h0, 6'h30, 2'b00, 1'b0, "R5 shl 16 R7");
      // R6 out-of-range shifts
      issue(3'd4, 1'b0, 16'h0, 16'h0, 6'd16, 2'b00, 1'b0, "R6 shamt 16");
      issue(3'd4, 1'b0, 16'h0, 16'h0, 6'h2F, 2'b00, 1'b0, "R6 shamt -17");
      issue(3'd4, 1'b1, 16'h0, 16'h0, 6'd31, 2'b00, 1'b0, "R6 shamt 31");
      issue(3'd4, 1'b1, 16'h0, 16'h0, 6'h20, 2'b00, 1'b0, "R6 shamt -32");
      // R10 clear, then R7 guard via MAC
      issue(3'd0, 1'b0, 16'h0, 16'h0, 6'd0, 2'b00, 1'b1, "R10 clear");
      issue(3'd3, 1'b0, 16'h7FFF, 16'hFFFF, 6'd0, 2'b00, 1'b0, "R3 load max32");
      issue(3'd1, 1'b0, 16'h0001, 16'h0001, 6'd0, 2'b00, 1'b0, "R7 guard mac");
      // R8 saturation on A, positive and negative
      issue(3'd4, 1'b0, 16'h0, 16'h0, 6'h30, 2'b01, 1'b0, "R8 clamp max");
      issue(3'd3, 1'b0, 16'h8000, 16'h0000, 6'd0, 2'b01, 1'b0, "R3 load min32");
      issue(3'd4, 1'b0, 16'h0, 16'h0, 6'h30, 2'b01, 1'b0, "R8 clamp min");
      // R9 no saturation on B: wrap and trap pulse
      issue(3'd3, 1'b1, 16'h7FFF, 16'hFFFF, 6'd0, 2'b01, 1'b0, "R3 load B");
      issue(3'd4, 1'b1, 16'h0, 16'h0, 6'h30, 2'b01, 1'b0, "R9 wrap trap");
      issue(3'd0, 1'b1, 16'h0, 16'h0, 6'd0, 2'b01, 1'b0, "R9 trap one cycle");
      // R9 catastrophic via MAC accumulation with sat off on A
      issue(3'd3, 1'b0, 16'h7FFF, 16'hFFFF, 6'd0, 2'b00, 1'b0, "R3 reload A");
      issue(3'd4, 1'b0, 16'h0, 16'h0, 6'h38, 2'b00, 1'b0, "R7 shl 8 guard");
      issue(3'd1, 1'b0, 16'h7FFF, 16'h7FFF, 6'd0, 2'b00, 1'b0, "R9 mac wrap");
      // R10 clear with simultaneous event, and plain clear
      issue(3'd1, 1'b0, 16'h7FFF, 16'h7FFF, 6'd0, 2'b00, 1'b1, "R10 clear+event");
      issue(3'd0, 1'b0, 16'h0, 16'h0, 6'd0, 2'b00, 1'b1, "R10 clear all");
      // R11 unused opcodes
      issue(3'd5, 1'b0, 16'h1111, 16'h2222, 6'd1, 2'b11, 1'b0, "R11 op5");
      issue(3'd6, 1'b1, 16'h7FFF, 16'h7FFF, 6'h30, 2'b00, 1'b0, "R11 op6");
      issue(3'd7, 1'b0, 16'h8000, 16'h8000, 6'd2, 2'b00, 1'b0, "R11 op7");
      // Mixed stream
      for (int k = 0; k < 200; k++) begin
         logic [2:0] rop;
         seed = seed * 32'd1664525 + 32'd1013904223;
         rop = (seed[31:29] == 3'd0) ? 3'd1 : seed[31:29];
         issue(rop, seed[28], seed[27:12], seed[15:0], seed[11:6], seed[5:4],
               seed[3:0] == 4'd0, "R2/R4/R5/R7/R8/R9 mixed");
      end
      nop(2);
      repeat (2) @(posedge clk);
      #2;
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule